// File: doc/BRIEF.md
# Trap and Interrupt Entry Sequencer

This block moves a processor core into and out of exception and interrupt handlers. It accepts three kinds of entry: synchronous requests from the pipeline (a trap raised by an instruction, a software interrupt instruction, or a system call), a non-maskable interrupt line, and a vectored external interrupt request. On every entry it copies the current instruction pointer, stack pointer and status word into three save registers. It then clears the interrupt-enable, user-mode and clock-stop bits of the live status word, reads the handler address from a 256-entry table in memory, and hands that address back to the pipeline with a one-cycle done pulse. A return request copies the three saved values back in a single step.

The block also owns the status word. The software-interrupt instruction and the return instruction are privileged. When either is issued with the user-mode bit set, it becomes an entry on the general-protection vector. The system call is allowed in user mode and always lands on the fixed operating-system vector. Setting the clock-stop bit parks the sequencer. If interrupts are enabled, only an interrupt wakes it. If they are disabled, only reset does.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the status word, all three save registers, `busy`, `done`, `halted` and `mem_rd_en` are zero.
- R2: On any entry, `save_ip` takes `cur_ip` and `save_sp` takes `cur_sp`. `save_stat` takes the prior status word with bit 19 cleared. `new_sp` equals `cur_sp` when `done` rises.
- R3: On any entry, status bits 16 (interrupt enable), 17 (user mode) and 19 (clock stop) are cleared, and every other status bit is kept.
- R4: The handler address is read from `TABLE_BASE + 4*vector`. `mem_rd_en` and `mem_addr` stay steady until `mem_ready` is high. `new_ip` carries the `mem_rdata` of that cycle, and `done` is high for exactly one cycle on the following cycle.
- R5: `req_kind` is encoded as 0 = trap on `req_vec`, 1 = software interrupt on `req_vec`, 2 = system call, 3 = return. A system call always uses vector 6, whatever `req_vec` holds.
- R6: A software interrupt or a return issued while status bit 17 is 1 becomes an entry on vector 4. `save_ip` then holds the `cur_ip` of that request.
- R7: A return issued while bit 17 is 0 makes `new_ip` equal `save_ip`, `new_sp` equal `save_sp` and the status word equal `save_stat`. `done` is high on the next cycle and no memory read is made.
- R8: The external request is taken only when status bit 16 is 1 and `irq_vec` is 32 or more. Otherwise it has no effect.
- R9: A rising edge on `nmi` causes an entry on vector 1 even when bit 16 is 0. A level that stays high causes no second entry.
- R10: When several sources are present in the same idle cycle, the pipeline request is served first, then the non-maskable interrupt, then the external request.
- R11: With status bit 19 set and bit 16 clear, `halted` stays high and requests, interrupts and status writes are all ignored until reset. With bits 19 and 16 both set, requests are ignored but an interrupt is taken, and the entry clears bit 19.
- R12: While idle, not halted and taking no entry, `stat_wr_en` loads `stat_wr_data` into the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Pipeline request present |
| req_kind | input | 2 | Request kind: 0 trap, 1 software interrupt, 2 system call, 3 return |
| req_vec | input | 8 | Vector number for trap and software interrupt |
| cur_ip | input | 32 | Instruction pointer to save |
| cur_sp | input | 32 | Stack pointer to save |
| nmi | input | 1 | Non-maskable interrupt, taken on a rising edge |
| irq_valid | input | 1 | External interrupt request level |
| irq_vec | input | 8 | External interrupt vector |
| stat_wr_en | input | 1 | Status word write strobe |
| stat_wr_data | input | 32 | Status word write value |
| mem_rd_en | output | 1 | Table read request |
| mem_addr | output | 32 | Table entry address |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Read data valid |
| done | output | 1 | One-cycle pulse: pipeline resumes at `new_ip` |
| new_ip | output | 32 | Instruction pointer to resume at |
| new_sp | output | 32 | Stack pointer to resume with |
| stat | output | 32 | Live status word |
| save_ip | output | 32 | Saved instruction pointer |
| save_sp | output | 32 | Saved stack pointer |
| save_stat | output | 32 | Saved status word |
| busy | output | 1 | Sequencer is not idle |
| halted | output | 1 | Parked by the clock-stop bit |

## Verification
The hardest situation to reach from the ports is a collision of all three entry sources in one idle cycle. The stimulus creates it by raising the pipeline request, an `nmi` edge and an external request on the same falling edge. It then checks that the pipeline entry is served first and that the pending non-maskable entry follows straight away. By then the first entry has cleared the enable bit, so the external request is left waiting. The parked state with interrupts disabled is also hard to reach. It can only be left by reset, so the stimulus drives a request, an `nmi` edge and a status write into it before applying reset. A 256-vector trap-and-return sweep and a sweep over all external vectors cover the table address arithmetic, using varying memory latencies.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [1:0] {
    K_TRAP    = 2'd0,
    K_SWINT   = 2'd1,
    K_SYSCALL = 2'd2,
    K_RETURN  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SAVE  = 2'd1,
    ST_FETCH = 2'd2,
    ST_JUMP  = 2'd3
  } seq_state_e;

  localparam int BIT_IE   = 16;
  localparam int BIT_USER = 17;
  localparam int BIT_STOP = 19;

  localparam int VEC_NMI       = 1;
  localparam int VEC_GPF       = 4;
  localparam int VEC_OSCALL    = 6;
  localparam int VEC_EXT_FIRST = 32;
endpackage

// File: rtl/trap_entry_arbiter.sv
module trap_entry_arbiter
  import trap_entry_pkg::*;
#(
  parameter int VW = 8
) (
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [VW-1:0] req_vec,
  input  logic          nmi_pend,
  input  logic          irq_valid,
  input  logic [VW-1:0] irq_vec,
  input  logic          ie,
  input  logic          user,
  input  logic          parked,
  output logic          take,
  output logic          take_ret,
  output logic          take_nmi,
  output logic [VW-1:0] take_vec
);
  localparam logic [VW-1:0] V_NMI = VW'(VEC_NMI);
  localparam logic [VW-1:0] V_GPF = VW'(VEC_GPF);
  localparam logic [VW-1:0] V_OS  = VW'(VEC_OSCALL);
  localparam logic [VW-1:0] V_EXT = VW'(VEC_EXT_FIRST);

  always_comb begin
    take     = 1'b0;
    take_ret = 1'b0;
    take_nmi = 1'b0;
    take_vec = '0;
    if (req_valid && !parked) begin
      take = 1'b1;
      case (req_kind)
        K_TRAP:    take_vec = req_vec;
        K_SWINT:   take_vec = user ? V_GPF : req_vec;
        K_SYSCALL: take_vec = V_OS;
        default: begin
          if (user) take_vec = V_GPF;
          else      take_ret = 1'b1;
        end
      endcase
    end else if (nmi_pend && (!parked || ie)) begin
      take     = 1'b1;
      take_nmi = 1'b1;
      take_vec = V_NMI;
    end else if (irq_valid && ie && (irq_vec >= V_EXT)) begin
      take     = 1'b1;
      take_vec = irq_vec;
    end
  end
endmodule

// File: rtl/trap_ctx_bank.sv
module trap_ctx_bank
  import trap_entry_pkg::*;
#(
  parameter int XW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_save,
  input  logic          do_restore,
  input  logic          do_write,
  input  logic [XW-1:0] in_ip,
  input  logic [XW-1:0] in_sp,
  input  logic [XW-1:0] wr_data,
  output logic [XW-1:0] stat,
  output logic [XW-1:0] sv_ip,
  output logic [XW-1:0] sv_sp,
  output logic [XW-1:0] sv_stat
);
  localparam logic [XW-1:0] M_STOP  = XW'(1) << BIT_STOP;
  localparam logic [XW-1:0] M_ENTRY = (XW'(1) << BIT_IE) | (XW'(1) << BIT_USER) | M_STOP;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat    <= '0;
      sv_ip   <= '0;
      sv_sp   <= '0;
      sv_stat <= '0;
    end else if (do_save) begin
      sv_ip   <= in_ip;
      sv_sp   <= in_sp;
      sv_stat <= stat & ~M_STOP;
      stat    <= stat & ~M_ENTRY;
    end else if (do_restore) begin
      stat <= sv_stat;
    end else if (do_write) begin
      stat <= wr_data;
    end
  end

  assert_entry_clears_R3: assert property (@(posedge clk) disable iff (rst)
    do_save |=> !stat[BIT_IE] && !stat[BIT_USER] && !stat[BIT_STOP]);

  assert_restore_word_R7: assert property (@(posedge clk) disable iff (rst)
    do_restore |=> stat == $past(sv_stat));
endmodule

// File: rtl/trap_vec_fetch.sv
module trap_vec_fetch #(
  parameter int          XW   = 32,
  parameter int          VW   = 8,
  parameter logic [31:0] BASE = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [VW-1:0] vec,
  input  logic          mem_ready,
  input  logic [XW-1:0] mem_rdata,
  output logic          mem_rd_en,
  output logic [XW-1:0] mem_addr,
  output logic          got,
  output logic [XW-1:0] got_data
);
  localparam int            ENTRY_SHIFT = 2;
  localparam logic [XW-1:0] BASE_W      = XW'(BASE);

  logic          rd_q;
  logic [XW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else if (start) begin
      rd_q   <= 1'b1;
      addr_q <= BASE_W + (XW'(vec) << ENTRY_SHIFT);
    end else if (rd_q && mem_ready) begin
      rd_q <= 1'b0;
    end
  end

  assign mem_rd_en = rd_q;
  assign mem_addr  = addr_q;
  assign got       = rd_q && mem_ready;
  assign got_data  = mem_rdata;

  assert_read_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_q && !mem_ready) |=> rd_q && $stable(addr_q));
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_entry_pkg::*;
#(
  parameter int          XW         = 32,
  parameter int          VW         = 8,
  parameter logic [31:0] TABLE_BASE = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [VW-1:0] req_vec,
  input  logic [XW-1:0] cur_ip,
  input  logic [XW-1:0] cur_sp,
  input  logic          nmi,
  input  logic          irq_valid,
  input  logic [VW-1:0] irq_vec,
  input  logic          stat_wr_en,
  input  logic [XW-1:0] stat_wr_data,
  output logic          mem_rd_en,
  output logic [XW-1:0] mem_addr,
  input  logic [XW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          done,
  output logic [XW-1:0] new_ip,
  output logic [XW-1:0] new_sp,
  output logic [XW-1:0] stat,
  output logic [XW-1:0] save_ip,
  output logic [XW-1:0] save_sp,
  output logic [XW-1:0] save_stat,
  output logic          busy,
  output logic          halted
);
  seq_state_e    state;
  logic [VW-1:0] vec_q;
  logic [XW-1:0] ip_q, sp_q, nip_q, nsp_q;
  logic          nmi_q, nmi_pend;

  logic          take, take_ret, take_nmi;
  logic [VW-1:0] take_vec;
  logic          idle, parked, enter, do_restore, do_write, got;
  logic [XW-1:0] got_data;

  assign idle   = (state == ST_IDLE);
  assign parked = idle && stat[BIT_STOP];

  trap_entry_arbiter #(.VW(VW)) u_arb (
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_vec   (req_vec),
    .nmi_pend  (nmi_pend),
    .irq_valid (irq_valid),
    .irq_vec   (irq_vec),
    .ie        (stat[BIT_IE]),
    .user      (stat[BIT_USER]),
    .parked    (parked),
    .take      (take),
    .take_ret  (take_ret),
    .take_nmi  (take_nmi),
    .take_vec  (take_vec)
  );

  assign enter      = idle && take;
  assign do_restore = enter && take_ret;
  assign do_write   = idle && !take && !parked && stat_wr_en;

  trap_ctx_bank #(.XW(XW)) u_ctx (
    .clk        (clk),
    .rst        (rst),
    .do_save    (state == ST_SAVE),
    .do_restore (do_restore),
    .do_write   (do_write),
    .in_ip      (ip_q),
    .in_sp      (sp_q),
    .wr_data    (stat_wr_data),
    .stat       (stat),
    .sv_ip      (save_ip),
    .sv_sp      (save_sp),
    .sv_stat    (save_stat)
  );

  trap_vec_fetch #(.XW(XW), .VW(VW), .BASE(TABLE_BASE)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start     (state == ST_SAVE),
    .vec       (vec_q),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .got       (got),
    .got_data  (got_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi;
      nmi_pend <= (nmi_pend && !(enter && take_nmi)) || (nmi && !nmi_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      vec_q <= '0;
      ip_q  <= '0;
      sp_q  <= '0;
      nip_q <= '0;
      nsp_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (enter) begin
            vec_q <= take_vec;
            ip_q  <= cur_ip;
            sp_q  <= cur_sp;
            if (take_ret) begin
              nip_q <= save_ip;
              nsp_q <= save_sp;
              state <= ST_JUMP;
            end else begin
              state <= ST_SAVE;
            end
          end
        end
        ST_SAVE:  state <= ST_FETCH;
        ST_FETCH: begin
          if (got) begin
            nip_q <= got_data;
            nsp_q <= sp_q;
            state <= ST_JUMP;
          end
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign done   = (state == ST_JUMP);
  assign new_ip = nip_q;
  assign new_sp = nsp_q;
  assign busy   = !idle;
  assign halted = parked;

  assert_done_single_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_parked_stays_R11: assert property (@(posedge clk) disable iff (rst)
    (halted && !stat[BIT_IE]) |=> halted);

  assert_return_no_read_R7: assert property (@(posedge clk) disable iff (rst)
    do_restore |=> !mem_rd_en && done);
endmodule

// File: tb/trap_entry_seq_bench.sv
`timescale 1ns/1ps
module trap_entry_seq_bench;
  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam logic [31:0] M_IE = 32'h0001_0000;
  localparam logic [31:0] M_US = 32'h0002_0000;
  localparam logic [31:0] M_ST = 32'h0008_0000;

  logic clk = 0, rst = 1;
  logic req_valid = 0, nmi = 0, irq_valid = 0, stat_wr_en = 0, mem_ready = 0;
  logic [1:0] req_kind = 0;
  logic [7:0] req_vec = 0, irq_vec = 0;
  logic [31:0] cur_ip = 0, cur_sp = 0, stat_wr_data = 0, mem_rdata = 0;
  logic mem_rd_en, done, busy, halted;
  logic [31:0] mem_addr, new_ip, new_sp, stat, save_ip, save_sp, save_stat;

  int n_run = 0, n_fail = 0, lat = 0, lat_cnt = 0, rd_cycles = 0;
  logic [31:0] cap_addr = 0;

  always #5 clk = ~clk;

  trap_entry_seq #(.TABLE_BASE(BASE)) u_trap_entry_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind), .req_vec(req_vec),
    .cur_ip(cur_ip), .cur_sp(cur_sp), .nmi(nmi), .irq_valid(irq_valid), .irq_vec(irq_vec),
    .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done),
    .new_ip(new_ip), .new_sp(new_sp), .stat(stat), .save_ip(save_ip), .save_sp(save_sp),
    .save_stat(save_stat), .busy(busy), .halted(halted));

  function automatic logic [31:0] table_val(input logic [31:0] a);
    return a * 32'd3 + 32'h0040_0000;
  endfunction

  // memory model: answers after lat extra cycles
  always @(negedge clk) begin
    if (mem_rd_en) begin
      rd_cycles++;
      if (lat_cnt >= lat) begin
        mem_ready <= 1; mem_rdata <= table_val(mem_addr); cap_addr <= mem_addr; lat_cnt <= 0;
      end else begin
        mem_ready <= 0; lat_cnt <= lat_cnt + 1;
      end
    end else begin
      mem_ready <= 0; lat_cnt <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [7:0] v);
    @(negedge clk); req_valid = 1; req_kind = k; req_vec = v;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic set_stat(input logic [31:0] v);
    @(negedge clk); stat_wr_en = 1; stat_wr_data = v;
    @(negedge clk); stat_wr_en = 0;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk({tag, " done seen"}, 32'(seen), 32'd1);
  endtask

  task automatic idle_for(input string tag, input int n);
    int b = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (busy) b++; end
    chk({tag, " stays idle"}, 32'(b), 32'd0);
  endtask

  task automatic check_entry(input string tag, input logic [7:0] ev, input logic [31:0] pre);
    logic [31:0] a;
    a = BASE + 32'(ev) * 4;
    chk({tag, " table addr R4"}, cap_addr, a);
    chk({tag, " new_ip R4"}, new_ip, table_val(a));
    chk({tag, " new_sp R2"}, new_sp, cur_sp);
    chk({tag, " save_ip R2"}, save_ip, cur_ip);
    chk({tag, " save_sp R2"}, save_sp, cur_sp);
    chk({tag, " save_stat R2"}, save_stat, pre & ~M_ST);
    chk({tag, " stat R3"}, stat, pre & ~(M_IE | M_US | M_ST));
    @(negedge clk);
    chk({tag, " done one cycle R4"}, 32'(done), 32'd0);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] pre;
    do_reset();
    // R1
    chk("R1 stat", stat, 0); chk("R1 save_ip", save_ip, 0); chk("R1 save_sp", save_sp, 0);
    chk("R1 save_stat", save_stat, 0); chk("R1 busy", 32'(busy), 0); chk("R1 done", 32'(done), 0);
    chk("R1 halted", 32'(halted), 0); chk("R1 rd_en", 32'(mem_rd_en), 0);

    // R5/R2/R3/R4/R7: trap on every vector, then return
    for (int v = 0; v < 256; v++) begin
      lat = v % 4;
      pre = (32'(v) << 24) | ((32'(v) & 3) << 16) | (32'(v) & 15);
      set_stat(pre);
      chk("R12 stat write", stat, pre);
      cur_ip = 32'h1000 + 32'(v) * 8; cur_sp = 32'h8000 - 32'(v);
      issue(2'd0, 8'(v));
      wait_done("R5 trap");
      check_entry("R5 trap", 8'(v), pre);
      rd_cycles = 0;
      cur_ip = 32'hDEAD_0000; cur_sp = 32'hBEEF_0000;
      issue(2'd3, 8'h00);
      wait_done("R7 return");
      chk("R7 new_ip", new_ip, 32'h1000 + 32'(v) * 8);
      chk("R7 new_sp", new_sp, 32'h8000 - 32'(v));
      chk("R7 stat", stat, pre);
      chk("R7 no read", 32'(rd_cycles), 0);
    end

    // R5 syscall from user mode, req_vec ignored
    lat = 1; cur_ip = 32'h2222; cur_sp = 32'h3333;
    set_stat(M_US | M_IE);
    issue(2'd2, 8'd77);
    wait_done("R5 syscall");
    check_entry("R5 syscall", 8'd6, M_US | M_IE);

    // R6 software interrupt and return in user mode
    set_stat(M_US | 32'h5);
    issue(2'd1, 8'd40);
    wait_done("R6 swint user");
    check_entry("R6 swint user", 8'd4, M_US | 32'h5);
    cur_ip = 32'h4444;
    set_stat(M_US);
    issue(2'd3, 8'd0);
    wait_done("R6 return user");
    check_entry("R6 return user", 8'd4, M_US);

    // R5 software interrupt in supervisor mode
    set_stat(32'h3);
    issue(2'd1, 8'd40);
    wait_done("R5 swint");
    check_entry("R5 swint", 8'd40, 32'h3);

    // R8 external interrupt masked or out of range
    set_stat(32'h0);
    @(negedge clk); irq_valid = 1; irq_vec = 8'd50;
    idle_for("R8 masked", 6);
    irq_vec = 8'd20;
    set_stat(M_IE);
    idle_for("R8 low vector", 6);
    chk("R8 stat untouched", stat, M_IE);
    irq_valid = 0;

    // R8 sweep of external vectors
    for (int v = 32; v < 256; v++) begin
      lat = v % 3; cur_ip = 32'h9000 + 32'(v); cur_sp = 32'h7000 + 32'(v);
      set_stat(M_IE | 32'(v & 3));
      @(negedge clk); irq_valid = 1; irq_vec = 8'(v);
      wait_done("R8 ext");
      irq_valid = 0;
      check_entry("R8 ext", 8'(v), M_IE | 32'(v & 3));
    end

    // R9 NMI with interrupts disabled, level held
    set_stat(M_US);
    @(negedge clk); nmi = 1;
    wait_done("R9 nmi");
    check_entry("R9 nmi", 8'd1, M_US);
    idle_for("R9 level held", 6);
    nmi = 0;

    // R10 three sources together
    set_stat(M_IE);
    cur_ip = 32'hAAAA; cur_sp = 32'hBBBB;
    @(negedge clk); req_valid = 1; req_kind = 2'd0; req_vec = 8'd9;
    nmi = 1; irq_valid = 1; irq_vec = 8'd60;
    @(negedge clk); req_valid = 0;
    wait_done("R10 first");
    check_entry("R10 pipeline first", 8'd9, M_IE);
    wait_done("R10 second");
    chk("R10 nmi second addr", cap_addr, BASE + 32'd4);
    @(negedge clk);
    idle_for("R10 ext waits", 6);
    nmi = 0; irq_valid = 0;

    // R11 parked with interrupts disabled
    set_stat(M_ST);
    chk("R11 halted", 32'(halted), 1);
    issue(2'd0, 8'd3);
    idle_for("R11 request ignored", 4);
    @(negedge clk); nmi = 1;
    idle_for("R11 nmi ignored", 4);
    nmi = 0;
    set_stat(32'h0);
    chk("R11 write ignored", stat, M_ST);
    chk("R11 still halted", 32'(halted), 1);
    do_reset();
    chk("R1 after reset stat", stat, 0);
    chk("R1 after reset halted", 32'(halted), 0);

    // R11 parked with interrupts enabled
    set_stat(M_ST | M_IE);
    issue(2'd0, 8'd3);
    idle_for("R11 request ignored ie", 4);
    cur_ip = 32'h5151; cur_sp = 32'h6161;
    @(negedge clk); irq_valid = 1; irq_vec = 8'd33;
    wait_done("R11 wake");
    irq_valid = 0;
    check_entry("R11 wake", 8'd33, M_ST | M_IE);
    chk("R11 awake", 32'(halted), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule